// File: doc/BRIEF.md
# Disk Card Wait-State Generator

This block drives the bus READY line of a floppy-disk expansion card. When the host CPU reads the disk controller's data register before the controller has a byte ready, the block pulls READY low. The CPU then sits in wait states until the controller raises its data request or its interrupt, or until the drive motor times out. The host bus fetches the odd byte of a word before the even byte. The block therefore watches a decoded strobe for the odd byte of the data register, so the stall begins before the data itself is sampled.

A retriggerable monostable creates the drive-enable signal. A rising edge on the motor control bit starts it, and it holds drive-enable high for a fixed number of clock cycles. That count is set by a parameter and stands for the 4.23 s spin time of the drive. When drive-enable drops, READY is evaluated again, so a CPU that is still waiting is released. The controller's interrupt request is also passed straight through to a separate interrupt output. Address decoding, the control register and the disk controller itself belong to neighbouring blocks.

Top module: `disk_wait_gen`

## Requirements
- R1: `bus_ready` is low only when all five conditions hold: `odd_data_sel`=1, `wait_en`=1, `ctl_drq`=0, `ctl_intrq`=0 and `drive_en`=1. For every other combination it is high.
- R2: While `wait_en`=0, `bus_ready` stays high whatever `ctl_drq` and `ctl_intrq` do.
- R3: When `ctl_drq` or `ctl_intrq` rises during a stall, `bus_ready` goes high in the same cycle, with no clock edge in between. When the line falls again, the stall returns in the same cycle.
- R4: When a clock edge samples `motor_strobe` high after it was low at the previous edge, `drive_en` goes high at that edge. It then stays high for exactly MOTOR_CYCLES clock cycles and goes low.
- R5: If `motor_strobe` is held high, it does not retrigger the monostable. After expiry, `drive_en` stays low until a new low-to-high transition of `motor_strobe`.
- R6: A new rising edge of `motor_strobe` while `drive_en` is high reloads the full count. `drive_en` then stays high for MOTOR_CYCLES cycles counted from that new edge.
- R7: When `drive_en` falls during a stall, `bus_ready` returns high in the same cycle, which releases the waiting CPU.
- R8: While `rst_n`=0 at a clock edge, `drive_en` is cleared and `bus_ready` is high. The remembered strobe level is also cleared, so a `motor_strobe` held high through reset counts as a rising edge at the first edge after reset is released.
- R9: `host_int` follows `ctl_intrq` combinationally, whether or not wait generation is enabled.
- R10: With `odd_data_sel`=0, `bus_ready` stays high even when every other stall condition holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| odd_data_sel | input | 1 | Decoded access to the odd byte of the controller data register |
| wait_en | input | 1 | Wait-state generation enable (control bit) |
| ctl_drq | input | 1 | Data request from the disk controller |
| ctl_intrq | input | 1 | Interrupt request from the disk controller |
| motor_strobe | input | 1 | Motor control bit; its rising edge triggers the monostable |
| bus_ready | output | 1 | READY to the host bus; low inserts wait states |
| drive_en | output | 1 | Drive-enable output of the motor monostable |
| host_int | output | 1 | Interrupt line to the host, a copy of ctl_intrq |

## Verification
The bench walks all sixteen combinations of select, enable, DRQ and INTRQ while the motor runs. A gate that left out one condition would stall or release on the wrong pattern. It counts how many cycles `drive_en` stays high after an edge, after a retrigger in mid-count and with the strobe held high. This catches an off-by-one terminal count, a counter that is not reloaded, and a monostable that triggers on level instead of edge. It checks that READY rises in the same cycle that DRQ, INTRQ or drive-enable release a stall; a registered READY would leave the CPU waiting one cycle too long. It also asserts reset with the strobe held high. A design that kept the old strobe level through reset would then miss the first trigger after reset.

// File: rtl/dwg_pkg.sv
// Package: shared types for the disk card wait-state generator.
// Assumes: all request inputs are already synchronous to clk.
package dwg_pkg;

    // Conditions that ask for or release a bus stall, grouped for the ready gate.
    typedef struct packed {
        logic odd_sel;   // odd byte of the data register is addressed
        logic wait_en;   // wait-state generation armed
        logic drq;       // controller has a byte
        logic intrq;     // controller finished the command
    } stall_req_t;

endpackage

// File: rtl/dwg_strobe_edge.sv
// Module: rising-edge detector for the motor control bit.
// Keeps the level seen at the previous clock edge. Reset clears this history,
// so a level that is high after reset counts as a rising edge.
module dwg_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic level_q;

    // Record the strobe level from the previous clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    // The current level is high and the previous one was low.
    assign rise = level & ~level_q;

    // A cleared history means a high level right after reset is seen as an edge.
    assert_hist_clear_R8: assert property (@(posedge clk)
        !rst_n |=> (level_q == 1'b0));

endmodule

// File: rtl/dwg_motor_mono.sv
// Module: retriggerable motor-on monostable.
// Each trigger pulse loads MOTOR_CYCLES into a down counter and sets drive_en.
// drive_en stays high for exactly MOTOR_CYCLES clock cycles after the trigger
// edge. A trigger while the count is running reloads the full count.
// Assumes: trig is a single-cycle pulse from an edge detector.
module dwg_motor_mono #(
    parameter int unsigned MOTOR_CYCLES = 21_150_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic drive_en
);
    localparam int unsigned CW = $clog2(MOTOR_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(MOTOR_CYCLES);
    localparam logic [CW-1:0] LAST_VAL = CW'(1);

    logic [CW-1:0] remain_q;
    logic          drive_q;

    // Load on a trigger, otherwise count down and drop the enable on the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            drive_q  <= 1'b0;
        end else if (trig) begin
            remain_q <= LOAD_VAL;
            drive_q  <= 1'b1;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
            if (remain_q == LAST_VAL) drive_q <= 1'b0;
        end
    end

    assign drive_en = drive_q;

    assert_trig_enables_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> drive_q);

    assert_trig_reloads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (remain_q == LOAD_VAL));

    assert_no_level_retrig_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && remain_q == '0) |=> !drive_q);

    assert_reset_clears_R8: assert property (@(posedge clk)
        !rst_n |=> !drive_q);

endmodule

// File: rtl/dwg_ready_gate.sv
// Module: combinational READY gate.
// Stalls the bus only when the odd data byte is addressed, waits are armed,
// neither DRQ nor INTRQ is present and the drive is enabled. The output
// changes in the same cycle as any input so the host is released at once.
// Assumes: clk is used only by the embedded checks.
module dwg_ready_gate
    import dwg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  stall_req_t req,
    input  logic       drive_en,
    output logic       ready
);
    logic stall;

    // Stall request: every condition has to hold, and never while reset is held.
    always_comb begin
        stall = rst_n & req.odd_sel & req.wait_en & ~req.drq & ~req.intrq & drive_en;
        ready = ~stall;
    end

    assert_wait_off_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req.wait_en |-> ready);

    assert_event_releases_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req.drq || req.intrq) |-> ready);

    assert_even_access_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req.odd_sel |-> ready);

endmodule

// File: rtl/disk_wait_gen.sv
// Module: wait-state generator top for a floppy controller expansion card.
// Builds the motor monostable from the edge of the motor control bit and
// uses its output with the bus and controller lines to drive READY. The
// controller interrupt is also forwarded to the host.
// Assumes: address decode and the control register are outside this block.
module disk_wait_gen #(
    parameter int unsigned MOTOR_CYCLES = 21_150_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic odd_data_sel,
    input  logic wait_en,
    input  logic ctl_drq,
    input  logic ctl_intrq,
    input  logic motor_strobe,
    output logic bus_ready,
    output logic drive_en,
    output logic host_int
);
    import dwg_pkg::*;

    logic       strobe_rise;
    stall_req_t req;

    // Group the stall conditions for the gate.
    always_comb begin
        req.odd_sel = odd_data_sel;
        req.wait_en = wait_en;
        req.drq     = ctl_drq;
        req.intrq   = ctl_intrq;
    end

    dwg_strobe_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (motor_strobe),
        .rise  (strobe_rise)
    );

    dwg_motor_mono #(.MOTOR_CYCLES(MOTOR_CYCLES)) u_mono (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (strobe_rise),
        .drive_en (drive_en)
    );

    dwg_ready_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .drive_en (drive_en),
        .ready    (bus_ready)
    );

    // Forward the controller interrupt to the host unchanged.
    assign host_int = ctl_intrq;

    assert_motor_off_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive_en) |-> bus_ready);

endmodule

// File: tb/test_disk_wait_gen.sv
`timescale 1ns/1ps
module test_disk_wait_gen;
    localparam int unsigned N = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic odd_data_sel = 1'b0, wait_en = 1'b0, ctl_drq = 1'b0, ctl_intrq = 1'b0;
    logic motor_strobe = 1'b0;
    logic bus_ready, drive_en, host_int;

    int checks = 0;
    int errors = 0;

    // Each entry: {odd_sel, wait_en, drq, intrq, expected_ready}
    localparam logic [4:0] VEC [16] = '{
        5'b0000_1, 5'b0001_1, 5'b0010_1, 5'b0011_1,
        5'b0100_1, 5'b0101_1, 5'b0110_1, 5'b0111_1,
        5'b1000_1, 5'b1001_1, 5'b1010_1, 5'b1011_1,
        5'b1100_0, 5'b1101_1, 5'b1110_1, 5'b1111_1
    };

    disk_wait_gen #(.MOTOR_CYCLES(N)) i_disk_wait_gen (
        .clk(clk), .rst_n(rst_n), .odd_data_sel(odd_data_sel), .wait_en(wait_en),
        .ctl_drq(ctl_drq), .ctl_intrq(ctl_intrq), .motor_strobe(motor_strobe),
        .bus_ready(bus_ready), .drive_en(drive_en), .host_int(host_int)
    );

    always #2.5 clk = ~clk;

    task automatic check(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", what, act, exp);
        end
    endtask

    // Count cycles drive_en stays high, sampled at negedges after the trigger edge.
    task automatic measure_high(output int cnt);
        cnt = 0;
        while (drive_en === 1'b1 && cnt < 4 * N) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int len;
        repeat (3) @(negedge clk);
        odd_data_sel = 1'b1; wait_en = 1'b1;
        #1;
        check(drive_en, 1'b0, "R8 drive_en in reset");
        check(bus_ready, 1'b1, "R8 ready in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_ready, 1'b1, "R1 ready with motor off");

        // Start motor and walk the table.
        motor_strobe = 1'b1;
        @(negedge clk);
        check(drive_en, 1'b1, "R4 drive_en after rise");
        motor_strobe = 1'b0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            {odd_data_sel, wait_en, ctl_drq, ctl_intrq} = VEC[i][4:1];
            #1;
            if (VEC[i][3] == 1'b0) check(bus_ready, VEC[i][0], "R2 vector");
            else if (VEC[i][4] == 1'b0) check(bus_ready, VEC[i][0], "R10 vector");
            else check(bus_ready, VEC[i][0], "R1 vector");
            check(host_int, VEC[i][1], "R9 host_int");
        end

        // Same-cycle release by DRQ and INTRQ.
        @(negedge clk);
        odd_data_sel = 1'b1; wait_en = 1'b1; ctl_drq = 1'b0; ctl_intrq = 1'b0;
        #1 check(bus_ready, 1'b0, "R3 stall set");
        ctl_drq = 1'b1;
        #0.5 check(bus_ready, 1'b1, "R3 drq release");
        ctl_drq = 1'b0;
        #0.5 check(bus_ready, 1'b0, "R3 drq restall");
        ctl_intrq = 1'b1;
        #0.5 check(bus_ready, 1'b1, "R3 intrq release");
        check(host_int, 1'b1, "R9 host_int high");
        ctl_intrq = 1'b0;
        #0.5 check(bus_ready, 1'b0, "R3 intrq restall");

        // Let motor expire while stalled: release at the fall.
        wait (drive_en === 1'b0);
        #0.1 check(bus_ready, 1'b1, "R7 release on expiry");

        // Exact duration.
        @(negedge clk); motor_strobe = 1'b1;
        @(negedge clk);
        measure_high(len);
        check(len == N, 1'b1, "R4 high length");
        // Strobe still high: no retrigger.
        repeat (N + 5) @(negedge clk);
        check(drive_en, 1'b0, "R5 held level no retrigger");

        // Retrigger mid-count.
        motor_strobe = 1'b0;
        @(negedge clk); motor_strobe = 1'b1;
        @(negedge clk); motor_strobe = 1'b0;
        repeat (10) @(negedge clk);
        motor_strobe = 1'b1;
        @(negedge clk);
        measure_high(len);
        check(len == N, 1'b1, "R6 reload length");

        // Reset with strobe held high, mid-run.
        @(negedge clk); motor_strobe = 1'b0;
        @(negedge clk); motor_strobe = 1'b1;
        @(negedge clk);
        check(drive_en, 1'b1, "R4 running before reset");
        rst_n = 1'b0;
        #1 check(bus_ready, 1'b1, "R8 ready during reset");
        @(negedge clk);
        check(drive_en, 1'b0, "R8 drive_en cleared");
        rst_n = 1'b1;
        @(negedge clk);
        check(drive_en, 1'b1, "R8 held strobe seen as edge");
        check(bus_ready, 1'b0, "R1 stall after reset retrigger");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule